// File: doc/BRIEF.md
# Bus Ownership Handover Controller

This controller sits on the external-agent side of a shared, multiplexed address/data system bus. When asked to, it takes the bus from the processor so that extra drivers and receivers can move a block of words between themselves without the processor taking part. Once the transfer is finished, it hands mastership back to the processor.

A handover always runs in the same order. The controller drives its active-low external-request line and waits for the processor's active-low release acknowledgement. It then holds slave-side ownership for the requested number of data cycles, with the active-low valid-in strobe asserted in every one of them. Next it sends a single-cycle null command that returns the bus to the processor. Finally it waits one cooldown cycle before it will accept another start.

The controller also measures release latency and classifies it. The latency is the number of cycles from the assertion of the request to the release. The category depends on what the processor was doing when the request went out: far from the end of its own request, in the tail of that request, or idle. A request that gets no release within a parameterised bound is abandoned and flagged as a timeout.

Top module: `bus_handover_ctrl`

## Requirements
- R1: While rst_ni is low and after reset, ext_req_no, vin_no and cmd_vld_no are high, and own_o, done_o, timeout_o, busy_o, lat_o and cat_o are zero.
- R2: When start_i is high in an idle cycle, ext_req_no goes low in the next cycle, called request cycle 1. It stays low in every following cycle for as long as rel_ni is sampled high, up to request cycle MAX_REL.
- R3: If rel_ni is low in a request cycle, ext_req_no is high from the next cycle onward.
- R4: Starting in the cycle after the release, vin_no is low and own_o is high for exactly len_i contiguous cycles, with len_i captured at start. With len_i = 0 there are no data cycles.
- R5: The measured latency equals the index k of the request cycle in which rel_ni was low (1 to MAX_REL). If rel_ni is low in cycle MAX_REL itself, the handover succeeds.
- R6: In the cycle after the last data cycle (or after the release when len_i = 0), cmd_vld_no is low for exactly one cycle with cmd_o equal to NULL_CMD. At all other times cmd_o is zero.
- R7: In the cycle after the null command, done_o pulses for one cycle. In that same cycle lat_o and cat_o show the new latency and category, and they keep those values until the next successful handover.
- R8: If rel_ni is still high in request cycle MAX_REL, ext_req_no is high in the next cycle and timeout_o pulses in that cycle. No data or null cycles follow, and lat_o and cat_o are left unchanged.
- R9: The category comes from proc_left_i as sampled in request cycle 1. proc_left_i encodes the processor's remaining request cycles: 0 = none in progress, 1 = final cycle, 2 = one before final, 3 = two or more before final. Value 3 gives cat_o = 1, values 1 or 2 give cat_o = 2, and value 0 gives cat_o = 3. Later values of proc_left_i are ignored.
- R10: start_i is ignored while a handover is running and in the cooldown cycle that carries done_o or timeout_o. In the cycle after the cooldown, ext_req_no is high and busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a handover (sampled when idle) |
| len_i | input | LEN_W | Number of data words, captured at start |
| proc_left_i | input | 2 | Processor request cycles remaining (encoding in R9) |
| rel_ni | input | 1 | Release acknowledgement from processor, active low |
| ext_req_no | output | 1 | External bus request, active low |
| vin_no | output | 1 | Valid-in strobe for data cycles, active low |
| cmd_o | output | CMD_W | Command lines; NULL_CMD during the null command |
| cmd_vld_no | output | 1 | Command strobe, active low |
| own_o | output | 1 | Enables the extra drivers while the agent owns the bus |
| done_o | output | 1 | One-cycle pulse when a handover completes |
| timeout_o | output | 1 | One-cycle pulse when a request is abandoned |
| lat_o | output | LAT_W | Last measured release latency in cycles |
| cat_o | output | 2 | Last release latency category (1 to 3) |
| busy_o | output | 1 | A handover is in progress |

## Verification
The bench builds the controller with MAX_REL = 8, LEN_W = 4 and a 4-bit command field. With the short latency bound, a timeout takes only a few cycles, so both timeouts and releases landing exactly in the last allowed request cycle show up often in the random mix. Lengths from zero to a few words cover the skipped data phase and single-word transfers. proc_left_i is changed after the first request cycle to show that the category is captured only once. Starts are pulsed during data and cooldown cycles to exercise the lockout.

// File: rtl/bho_pkg.sv
package bho_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_XFER = 3'd2,
    ST_NULL = 3'd3,
    ST_COOL = 3'd4
  } st_e;

  // proc_left: 0 none, 1 final, 2 one before final, 3 two or more before final
  function automatic logic [1:0] cat_of(logic [1:0] left);
    logic [1:0] c;
    case (left)
      2'd3:    c = 2'd1;
      2'd2,
      2'd1:    c = 2'd2;
      default: c = 2'd3;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/bho_fsm.sv
module bho_fsm
  import bho_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rel_ni,
  input  logic lat_full_i,
  input  logic len_zero_i,
  input  logic last_word_i,
  output st_e  st_o,
  output logic fail_o
);
  st_e  st_q, st_d;
  logic fail_q, fail_d;

  always_comb begin
    st_d   = st_q;
    fail_d = fail_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_REQ;
      ST_REQ: begin
        if (!rel_ni) begin
          st_d   = len_zero_i ? ST_NULL : ST_XFER;
          fail_d = 1'b0;
        end else if (lat_full_i) begin
          st_d   = ST_COOL;
          fail_d = 1'b1;
        end
      end
      ST_XFER: if (last_word_i) st_d = ST_NULL;
      ST_NULL: st_d = ST_COOL;
      ST_COOL: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      fail_q <= fail_d;
    end
  end

  assign st_o   = st_q;
  assign fail_o = fail_q;
endmodule

// File: rtl/bho_lat_meter.sv
module bho_lat_meter
  import bho_pkg::*;
#(
  parameter int MAX_REL = 16,
  parameter int LAT_W   = $clog2(MAX_REL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  st_e              st_i,
  input  logic             start_i,
  input  logic             rel_ni,
  input  logic [1:0]       proc_left_i,
  output logic             full_o,
  output logic [LAT_W-1:0] lat_o,
  output logic [1:0]       cat_o
);
  localparam logic [LAT_W-1:0] LimC = LAT_W'(MAX_REL);
  localparam logic [LAT_W-1:0] OneC = LAT_W'(1);

  logic [LAT_W-1:0] cnt_q, pend_lat_q, lat_q;
  logic [1:0]       cap_cat_q, pend_cat_q, cat_q;
  logic             first_c;

  assign first_c = (st_i == ST_REQ) && (cnt_q == OneC);
  assign full_o  = (cnt_q == LimC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      cap_cat_q  <= '0;
      pend_lat_q <= '0;
      pend_cat_q <= '0;
      lat_q      <= '0;
      cat_q      <= '0;
    end else begin
      if (st_i == ST_IDLE && start_i) cnt_q <= OneC;
      else if (st_i == ST_REQ && rel_ni && !full_o) cnt_q <= cnt_q + OneC;

      if (first_c) cap_cat_q <= cat_of(proc_left_i);

      if (st_i == ST_REQ && !rel_ni) begin
        pend_lat_q <= cnt_q;
        pend_cat_q <= first_c ? cat_of(proc_left_i) : cap_cat_q;
      end

      // publish only on a completed handover
      if (st_i == ST_NULL) begin
        lat_q <= pend_lat_q;
        cat_q <= pend_cat_q;
      end
    end
  end

  assign lat_o = lat_q;
  assign cat_o = cat_q;
endmodule

// File: rtl/bho_word_seq.sv
module bho_word_seq
  import bho_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  st_e              st_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             zero_o,
  output logic             last_o
);
  localparam logic [LEN_W-1:0] OneC = LEN_W'(1);

  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
    end else if (st_i == ST_IDLE && start_i) begin
      rem_q <= len_i;
    end else if (st_i == ST_XFER) begin
      rem_q <= rem_q - OneC;
    end
  end

  assign zero_o = (rem_q == '0);
  assign last_o = (rem_q == OneC);
endmodule

// File: rtl/bus_handover_ctrl.sv
module bus_handover_ctrl
  import bho_pkg::*;
#(
  parameter int               MAX_REL  = 16,
  parameter int               LEN_W    = 8,
  parameter int               CMD_W    = 4,
  parameter logic [CMD_W-1:0] NULL_CMD = CMD_W'(4'b1011),
  localparam int              LAT_W    = $clog2(MAX_REL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [1:0]       proc_left_i,
  input  logic             rel_ni,
  output logic             ext_req_no,
  output logic             vin_no,
  output logic [CMD_W-1:0] cmd_o,
  output logic             cmd_vld_no,
  output logic             own_o,
  output logic             done_o,
  output logic             timeout_o,
  output logic [LAT_W-1:0] lat_o,
  output logic [1:0]       cat_o,
  output logic             busy_o
);
  st_e  st;
  logic fail, lat_full, len_zero, last_word;

  bho_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .rel_ni     (rel_ni),
    .lat_full_i (lat_full),
    .len_zero_i (len_zero),
    .last_word_i(last_word),
    .st_o       (st),
    .fail_o     (fail)
  );

  bho_lat_meter #(.MAX_REL(MAX_REL), .LAT_W(LAT_W)) u_lat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .st_i       (st),
    .start_i    (start_i),
    .rel_ni     (rel_ni),
    .proc_left_i(proc_left_i),
    .full_o     (lat_full),
    .lat_o      (lat_o),
    .cat_o      (cat_o)
  );

  bho_word_seq #(.LEN_W(LEN_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .st_i   (st),
    .start_i(start_i),
    .len_i  (len_i),
    .zero_o (len_zero),
    .last_o (last_word)
  );

  assign ext_req_no = (st != ST_REQ);
  assign vin_no     = (st != ST_XFER);
  assign own_o      = (st == ST_XFER);
  assign cmd_vld_no = (st != ST_NULL);
  assign cmd_o      = (st == ST_NULL) ? NULL_CMD : '0;
  assign done_o     = (st == ST_COOL) && !fail;
  assign timeout_o  = (st == ST_COOL) && fail;
  assign busy_o     = (st != ST_IDLE);
endmodule

// File: rtl/bho_checker.sv
module bho_checker #(
  parameter int               MAX_REL  = 16,
  parameter int               CMD_W    = 4,
  parameter logic [CMD_W-1:0] NULL_CMD = '0,
  parameter int               LAT_W    = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ext_req_no,
  input logic             rel_ni,
  input logic             vin_no,
  input logic             own_o,
  input logic             cmd_vld_no,
  input logic [CMD_W-1:0] cmd_o,
  input logic             done_o,
  input logic             timeout_o,
  input logic [LAT_W-1:0] lat_o,
  input logic [1:0]       cat_o
);
  AST_REQ_DROP_AFTER_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_req_no && !rel_ni) |=> ext_req_no); // R3
  AST_VIN_WITH_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vin_no |-> (own_o && ext_req_no)); // R4
  AST_NULL_CMD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_vld_no |-> (cmd_o == NULL_CMD)); // R6
  AST_NULL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_vld_no |=> cmd_vld_no); // R6
  AST_DONE_AFTER_NULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cmd_vld_no) == 1'b0); // R7
  AST_LAT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_o >= LAT_W'(1) && lat_o <= LAT_W'(MAX_REL))); // R5
  AST_CAT_CODED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cat_o != 2'd0)); // R9
  AST_TIMEOUT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (ext_req_no && vin_no && cmd_vld_no && !done_o)); // R8
  AST_NO_REQ_IN_COOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || timeout_o) |=> ext_req_no); // R10
  AST_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({!ext_req_no, !vin_no, !cmd_vld_no, done_o || timeout_o})); // R2
endmodule

bind bus_handover_ctrl bho_checker #(
  .MAX_REL (MAX_REL),
  .CMD_W   (CMD_W),
  .NULL_CMD(NULL_CMD),
  .LAT_W   (LAT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ext_req_no(ext_req_no),
  .rel_ni    (rel_ni),
  .vin_no    (vin_no),
  .own_o     (own_o),
  .cmd_vld_no(cmd_vld_no),
  .cmd_o     (cmd_o),
  .done_o    (done_o),
  .timeout_o (timeout_o),
  .lat_o     (lat_o),
  .cat_o     (cat_o)
);

// File: tb/sim_bus_handover_ctrl.sv
`timescale 1ns/1ps
module sim_bus_handover_ctrl;
  localparam int             MAX_REL  = 8;
  localparam int             LEN_W    = 4;
  localparam int             CMD_W    = 4;
  localparam logic [3:0]     NULL_CMD = 4'b1011;
  localparam int             LAT_W    = $clog2(MAX_REL + 1);

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [LEN_W-1:0] len_i = '0;
  logic [1:0]       proc_left_i = '0;
  logic             rel_ni = 1'b1;
  logic             ext_req_no, vin_no, cmd_vld_no, own_o, done_o, timeout_o, busy_o;
  logic [CMD_W-1:0] cmd_o;
  logic [LAT_W-1:0] lat_o;
  logic [1:0]       cat_o;

  int n_tests = 0;
  int n_fail  = 0;
  int prev_lat = 0;
  int prev_cat = 0;

  always #2.5 clk = ~clk;

  bus_handover_ctrl #(
    .MAX_REL(MAX_REL), .LEN_W(LEN_W), .CMD_W(CMD_W), .NULL_CMD(NULL_CMD)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .len_i(len_i),
    .proc_left_i(proc_left_i), .rel_ni(rel_ni), .ext_req_no(ext_req_no),
    .vin_no(vin_no), .cmd_o(cmd_o), .cmd_vld_no(cmd_vld_no), .own_o(own_o),
    .done_o(done_o), .timeout_o(timeout_o), .lat_o(lat_o), .cat_o(cat_o),
    .busy_o(busy_o)
  );

  function automatic int exp_cat(int left);
    if (left == 3) return 1;
    if (left == 0) return 3;
    return 2;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // d: request cycle in which release is driven low; d > MAX_REL means never
  task automatic handover(int len, int left, int d);
    bit released = 1'b0;
    start_i = 1'b1; len_i = LEN_W'(len); proc_left_i = 2'(left);
    @(negedge clk);
    start_i = 1'b0;
    chk(ext_req_no == 1'b0 && busy_o, "R2 request asserted", int'(ext_req_no), 0);
    for (int i = 1; i <= MAX_REL; i++) begin
      if (i == d) rel_ni = 1'b0;
      if (i == 2) proc_left_i = 2'(left + 1); // must not alter the category (R9)
      @(negedge clk);
      rel_ni = 1'b1;
      if (i == d) begin released = 1'b1; break; end
      if (i < MAX_REL)
        chk(ext_req_no == 1'b0, "R2 request held", int'(ext_req_no), 0);
    end
    if (released) begin
      chk(ext_req_no == 1'b1, "R3 request dropped", int'(ext_req_no), 1);
      for (int w = 0; w < len; w++) begin
        chk(vin_no == 1'b0 && own_o, "R4 data cycle", int'(vin_no), 0);
        start_i = (w == 0); // ignored mid-transfer (R10)
        @(negedge clk);
      end
      start_i = 1'b0;
      chk(vin_no == 1'b1 && !own_o, "R4 data length", int'(vin_no), 1);
      chk(cmd_vld_no == 1'b0, "R6 null strobe", int'(cmd_vld_no), 0);
      chk(cmd_o == NULL_CMD, "R6 null code", int'(cmd_o), int'(NULL_CMD));
      @(negedge clk);
      chk(cmd_vld_no == 1'b1, "R6 single cycle", int'(cmd_vld_no), 1);
      chk(done_o == 1'b1 && !timeout_o, "R7 done pulse", int'(done_o), 1);
      chk(int'(lat_o) == d, "R5 latency", int'(lat_o), d);
      chk(int'(cat_o) == exp_cat(left), "R9 category", int'(cat_o), exp_cat(left));
      prev_lat = d; prev_cat = exp_cat(left);
    end else begin
      chk(timeout_o == 1'b1 && !done_o, "R8 timeout pulse", int'(timeout_o), 1);
      chk(ext_req_no == 1'b1 && vin_no && cmd_vld_no, "R8 request abandoned",
          int'(ext_req_no), 1);
      chk(int'(lat_o) == prev_lat, "R8 latency kept", int'(lat_o), prev_lat);
      chk(int'(cat_o) == prev_cat, "R8 category kept", int'(cat_o), prev_cat);
    end
    start_i = 1'b1; // cooldown: must be ignored (R10)
    @(negedge clk);
    start_i = 1'b0;
    chk(ext_req_no == 1'b1 && !busy_o && !done_o && !timeout_o, "R10 lockout",
        int'(busy_o), 0);
    chk(int'(lat_o) == prev_lat, "R7 status held", int'(lat_o), prev_lat);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ext_req_no && vin_no && cmd_vld_no && !own_o && !done_o && !timeout_o &&
        !busy_o && lat_o == '0 && cat_o == '0, "R1 reset state", int'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(ext_req_no && !busy_o && lat_o == '0, "R1 after reset", int'(ext_req_no), 1);
    handover(3, 3, 1);
    handover(0, 1, 2);
    handover(2, 2, MAX_REL);
    handover(1, 0, MAX_REL + 1);
    handover(4, 0, 5);
    handover(1, 3, MAX_REL + 2);
    void'($urandom(32'd4242));
    for (int k = 0; k < 60; k++) begin
      int len  = int'($urandom_range(0, 5));
      int left = int'($urandom_range(0, 3));
      int d    = int'($urandom_range(1, MAX_REL + 2));
      handover(len, left, d);
      if ($urandom_range(0, 2) == 0) @(negedge clk);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule